// File: doc/BRIEF.md
# Interrupt Acknowledge and Autovector Responder

This block sits on a processor bus and answers interrupt-acknowledge cycles. It recognises an acknowledge from the function-code lines and reads the acknowledged priority level from three address lines while the address strobe is low. A per-level configuration bit chooses between two ways of answering. A vectored level places a vector byte from its device on the data bus and asserts data acknowledge. An autovectored level asserts valid-peripheral-address instead, so the processor takes the fixed entry for that level.

Each answer also comes with the byte address of the selected entry in a 256-entry longword vector table. If a vectored device never offers a vector, the block ends the cycle after a bounded wait and returns the spurious-interrupt vector 24. The same happens at once for an acknowledge at level 0. That way every acknowledge ends in a defined table entry. Priority encoding of interrupt requests is handled elsewhere.

Top module: `irq_ack_responder`

## Requirements
- R1: An acknowledge is recognised only when `fc_i` equals 3'b111 and `as_n_i` is 0. In every other case `dtack_n_o` and `vpa_n_o` stay 1.
- R2: When `auto_cfg_i[L]` is 1 and the acknowledged level L is 1 to 7, `vpa_n_o` goes to 0 and `dtack_n_o` stays 1, starting from the sample after the first clock edge that sees the acknowledge. `tbl_addr_o` then equals (24+L)*4, so level 2 gives vector 26 and address 0x068.
- R3: For a vectored level L (`auto_cfg_i[L]` = 0), the first clock edge during the acknowledge at which `dev_valid_i[L]` is 1 causes `dtack_n_o` = 0 and `vpa_n_o` = 1. At the same time `data_o` shows byte L of `dev_vec_i` (bits 8L+7 to 8L), and `tbl_addr_o` = that vector * 4.
- R4: If `dev_valid_i[L]` stays 0 for TIMEOUT clock edges after the recognising edge, the block answers with `dtack_n_o` = 0, `data_o` = 24 and `tbl_addr_o` = 0x060.
- R5: If `dev_valid_i[L]` is first seen at exactly the edge on which the timeout would fire, the device vector is returned and not the spurious one.
- R6: An acknowledge at level 0 is answered at the first edge with data acknowledge and vector 24, whatever the configuration.
- R7: `dtack_n_o` and `vpa_n_o` are never 0 together. Both return to 1 in the same cycle in which `as_n_i` returns to 1, with no clock edge needed.
- R8: Once the answer is given, `data_o` and `tbl_addr_o` stay unchanged while `as_n_i` stays 0, even if `dev_vec_i` or `dev_valid_i` change.
- R9: `data_o` is 0 and `tbl_addr_o` is 0 whenever neither acknowledge output is asserted.
- R10: After synchronous reset, `dtack_n_o` = 1, `vpa_n_o` = 1, `data_o` = 0 and `tbl_addr_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fc_i | input | 3 | Function-code lines |
| lvl_i | input | 3 | Acknowledged level from address bits 3 to 1 |
| as_n_i | input | 1 | Address strobe, active low |
| auto_cfg_i | input | 8 | Bit L = 1 makes level L autovectored; bit 0 unused |
| dev_valid_i | input | 8 | Bit L = 1 means the device at level L offers a vector |
| dev_vec_i | input | 64 | Device vector bytes, byte L belongs to level L |
| data_o | output | 8 | Vector byte on the low data lines |
| dtack_n_o | output | 1 | Data acknowledge, active low |
| vpa_n_o | output | 1 | Valid peripheral address, active low |
| tbl_addr_o | output | 10 | Byte address of the selected vector table entry |

## Verification
The wait for a device vector and the timeout can end in the same cycle. The bench provokes this by raising the device's valid bit so that it is first sampled at exactly the TIMEOUT-th edge after recognition, and by raising it one edge later as well. The first case must return the device byte and the second the spurious vector 24. The end of the strobe is the second meeting point. The bench releases the strobe while an answer is held and checks, in that same cycle, that both acknowledge outputs have already returned high. Randomised acknowledges with random delays, levels and configurations cover the space between these points. Their expected cycle and value are computed from the requirements.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    localparam int VEC_W      = 8;
    localparam int LVL_W      = 3;
    localparam int NUM_LVL    = 1 << LVL_W;
    localparam int TBL_AW     = VEC_W + 2;
    localparam logic [2:0] FC_ACK = 3'b111;

    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [TBL_AW-1:0] tbl_addr_t;

    localparam vec_t VEC_SPURIOUS  = vec_t'(24);
    localparam vec_t VEC_AUTO_BASE = vec_t'(24);

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} ack_state_e;
    typedef enum logic [1:0] {ANS_NONE, ANS_DATA, ANS_AUTO} answer_e;

    typedef struct packed {
        answer_e kind;
        vec_t    vec;
    } answer_t;

    function automatic vec_t auto_vector(input lvl_t lvl);
        return VEC_AUTO_BASE + vec_t'(lvl);
    endfunction

    function automatic tbl_addr_t entry_address(input vec_t v);
        return {v, 2'b00};
    endfunction
endpackage

// File: rtl/irq_ack_decode.sv
module irq_ack_decode
    import irq_ack_pkg::*;
(
    input  logic [2:0]             fc_i,
    input  lvl_t                   lvl_i,
    input  logic                   as_n_i,
    input  logic [NUM_LVL-1:0]     auto_cfg_i,
    input  logic [NUM_LVL-1:0]     dev_valid_i,
    input  logic [NUM_LVL*VEC_W-1:0] dev_vec_i,
    output logic                   ack_cycle_o,
    output logic                   lvl_zero_o,
    output logic                   lvl_auto_o,
    output logic                   dev_ok_o,
    output vec_t                   dev_vec_o,
    output vec_t                   auto_vec_o
);
    vec_t per_lvl [NUM_LVL];

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_unpack
        assign per_lvl[g] = dev_vec_i[g*VEC_W +: VEC_W];
    end

    always_comb begin
        ack_cycle_o = (fc_i == FC_ACK) && !as_n_i;
        lvl_zero_o  = (lvl_i == '0);
        lvl_auto_o  = auto_cfg_i[lvl_i];
        dev_ok_o    = dev_valid_i[lvl_i];
        dev_vec_o   = per_lvl[lvl_i];
        auto_vec_o  = auto_vector(lvl_i);
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_ack_pkg::*;
#(
    parameter int TIMEOUT = 8
)(
    input  logic    clk,
    input  logic    rst,
    input  logic    as_n_i,
    input  logic    ack_cycle_i,
    input  logic    lvl_zero_i,
    input  logic    lvl_auto_i,
    input  logic    dev_ok_i,
    input  vec_t    dev_vec_i,
    input  vec_t    auto_vec_i,
    output answer_t answer_o,
    output logic    held_o
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    ack_state_e       st_q;
    logic [CNT_W-1:0] wait_q;
    answer_t          ans_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            wait_q <= '0;
            ans_q  <= '{kind: ANS_NONE, vec: '0};
        end else begin
            case (st_q)
                ST_IDLE: begin
                    wait_q <= '0;
                    if (ack_cycle_i) begin
                        if (lvl_zero_i) begin
                            ans_q <= '{kind: ANS_DATA, vec: VEC_SPURIOUS};
                            st_q  <= ST_DONE;
                        end else if (lvl_auto_i) begin
                            ans_q <= '{kind: ANS_AUTO, vec: auto_vec_i};
                            st_q  <= ST_DONE;
                        end else if (dev_ok_i) begin
                            ans_q <= '{kind: ANS_DATA, vec: dev_vec_i};
                            st_q  <= ST_DONE;
                        end else begin
                            st_q  <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (as_n_i) begin
                        st_q <= ST_IDLE;
                    end else if (dev_ok_i) begin
                        ans_q <= '{kind: ANS_DATA, vec: dev_vec_i};
                        st_q  <= ST_DONE;
                    end else if (wait_q == CNT_LAST) begin
                        ans_q <= '{kind: ANS_DATA, vec: VEC_SPURIOUS};
                        st_q  <= ST_DONE;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    if (as_n_i) begin
                        ans_q <= '{kind: ANS_NONE, vec: '0};
                        st_q  <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign answer_o = ans_q;
    assign held_o   = (st_q == ST_DONE);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !ack_cycle_i) |=> (st_q == ST_IDLE));

    assert_wait_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT) |-> (wait_q < CNT_W'(TIMEOUT)));

    assert_answer_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DONE && $past(st_q) == ST_DONE) |-> $stable(ans_q));
endmodule

// File: rtl/irq_ack_outmux.sv
module irq_ack_outmux
    import irq_ack_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      as_n_i,
    input  logic      held_i,
    input  answer_t   answer_i,
    output vec_t      data_o,
    output logic      dtack_n_o,
    output logic      vpa_n_o,
    output tbl_addr_t tbl_addr_o
);
    logic live;

    always_comb begin
        live       = held_i && !as_n_i;
        dtack_n_o  = !(live && answer_i.kind == ANS_DATA);
        vpa_n_o    = !(live && answer_i.kind == ANS_AUTO);
        data_o     = !dtack_n_o ? answer_i.vec : '0;
        tbl_addr_o = live ? entry_address(answer_i.vec) : '0;
    end

    assert_never_both_R7: assert property (@(posedge clk) disable iff (rst)
        !(!dtack_n_o && !vpa_n_o));

    assert_strobe_gate_R7: assert property (@(posedge clk) disable iff (rst)
        as_n_i |-> (dtack_n_o && vpa_n_o));

    assert_auto_range_R2: assert property (@(posedge clk) disable iff (rst)
        !vpa_n_o |-> (tbl_addr_o >= tbl_addr_t'(100) && tbl_addr_o <= tbl_addr_t'(124)));
endmodule

// File: rtl/irq_ack_responder.sv
module irq_ack_responder
    import irq_ack_pkg::*;
#(
    parameter int TIMEOUT = 8
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [2:0]               fc_i,
    input  logic [2:0]               lvl_i,
    input  logic                     as_n_i,
    input  logic [7:0]               auto_cfg_i,
    input  logic [7:0]               dev_valid_i,
    input  logic [63:0]              dev_vec_i,
    output logic [7:0]               data_o,
    output logic                     dtack_n_o,
    output logic                     vpa_n_o,
    output logic [9:0]               tbl_addr_o
);
    logic    ack_cycle, lvl_zero, lvl_auto, dev_ok, held;
    vec_t    dev_vec, auto_vec;
    answer_t answer;

    irq_ack_decode u_decode (
        .fc_i        (fc_i),
        .lvl_i       (lvl_i),
        .as_n_i      (as_n_i),
        .auto_cfg_i  (auto_cfg_i),
        .dev_valid_i (dev_valid_i),
        .dev_vec_i   (dev_vec_i),
        .ack_cycle_o (ack_cycle),
        .lvl_zero_o  (lvl_zero),
        .lvl_auto_o  (lvl_auto),
        .dev_ok_o    (dev_ok),
        .dev_vec_o   (dev_vec),
        .auto_vec_o  (auto_vec)
    );

    irq_ack_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .as_n_i      (as_n_i),
        .ack_cycle_i (ack_cycle),
        .lvl_zero_i  (lvl_zero),
        .lvl_auto_i  (lvl_auto),
        .dev_ok_i    (dev_ok),
        .dev_vec_i   (dev_vec),
        .auto_vec_i  (auto_vec),
        .answer_o    (answer),
        .held_o      (held)
    );

    irq_ack_outmux u_out (
        .clk        (clk),
        .rst        (rst),
        .as_n_i     (as_n_i),
        .held_i     (held),
        .answer_i   (answer),
        .data_o     (data_o),
        .dtack_n_o  (dtack_n_o),
        .vpa_n_o    (vpa_n_o),
        .tbl_addr_o (tbl_addr_o)
    );
endmodule

// File: tb/irq_ack_responder_test.sv
module irq_ack_responder_test;
    localparam int TO = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  fc_i = 3'b000;
    logic [2:0]  lvl_i = 3'b000;
    logic        as_n_i = 1'b1;
    logic [7:0]  auto_cfg_i = 8'h00;
    logic [7:0]  dev_valid_i = 8'h00;
    logic [63:0] dev_vec_i = 64'h0;
    logic [7:0]  data_o;
    logic        dtack_n_o, vpa_n_o;
    logic [9:0]  tbl_addr_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    irq_ack_responder #(.TIMEOUT(TO)) uut (
        .clk(clk), .rst(rst), .fc_i(fc_i), .lvl_i(lvl_i), .as_n_i(as_n_i),
        .auto_cfg_i(auto_cfg_i), .dev_valid_i(dev_valid_i), .dev_vec_i(dev_vec_i),
        .data_o(data_o), .dtack_n_o(dtack_n_o), .vpa_n_o(vpa_n_o), .tbl_addr_o(tbl_addr_o)
    );

    function automatic logic [19:0] pack_exp(input bit dt_n, input bit vp_n,
                                              input logic [7:0] d, input logic [9:0] a);
        return {dt_n, vp_n, d, a};
    endfunction

    task automatic check_out(input logic [19:0] exp, input string tag);
        logic [19:0] act;
        act = {dtack_n_o, vpa_n_o, data_o, tbl_addr_o};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual dtack_n=%b vpa_n=%b data=%0d addr=0x%03h expected dtack_n=%b vpa_n=%b data=%0d addr=0x%03h",
                     tag, act[19], act[18], act[17:10], act[9:0],
                     exp[19], exp[18], exp[17:10], exp[9:0]);
        end
    endtask

    // One acknowledge: level, autovector choice, device delay d (edges after recognition), vector byte
    task automatic run_ack(input int lvl, input bit auto_sel, input int d,
                           input logic [7:0] v, input string tag);
        int resp_at;
        bit use_vpa;
        logic [7:0] ev;
        @(negedge clk);
        auto_cfg_i  = 8'($urandom);
        auto_cfg_i[lvl] = auto_sel;
        dev_vec_i   = {$urandom, $urandom};
        dev_vec_i[lvl*8 +: 8] = v;
        dev_valid_i = 8'($urandom);
        dev_valid_i[lvl] = (d == 0);
        fc_i   = 3'b111;
        lvl_i  = 3'(lvl);
        as_n_i = 1'b0;
        use_vpa = 1'b0;
        if (lvl == 0) begin
            resp_at = 0; ev = 8'd24;
        end else if (auto_sel) begin
            resp_at = 0; ev = 8'(24 + lvl); use_vpa = 1'b1;
        end else if (d <= TO) begin
            resp_at = d; ev = v;
        end else begin
            resp_at = TO; ev = 8'd24;
        end
        for (int t = 0; t <= TO + 2; t++) begin
            @(negedge clk);
            if (t < resp_at)
                check_out(pack_exp(1'b1, 1'b1, 8'd0, 10'd0), {tag, "/R9 waiting"});
            else if (use_vpa)
                check_out(pack_exp(1'b1, 1'b0, 8'd0, {ev, 2'b00}),
                          t > resp_at ? {tag, "/R8"} : tag);
            else
                check_out(pack_exp(1'b0, 1'b1, ev, {ev, 2'b00}),
                          t > resp_at ? {tag, "/R8"} : tag);
            if (lvl != 0 && !auto_sel && t + 1 == d) dev_valid_i[lvl] = 1'b1;
            if (t == resp_at) begin
                dev_vec_i   = {$urandom, $urandom};   // R8 stimulus
                dev_valid_i = 8'($urandom);
            end
        end
        @(negedge clk);
        as_n_i = 1'b1;
        #1;
        check_out(pack_exp(1'b1, 1'b1, 8'd0, 10'd0), {tag, "/R7 strobe release"});
        fc_i = 3'b000;
    endtask

    initial begin
        void'($urandom(32'h5EED_1ACC));
        repeat (3) @(negedge clk);
        check_out(pack_exp(1'b1, 1'b1, 8'd0, 10'd0), "R10 reset");
        rst = 1'b0;
        @(negedge clk);
        check_out(pack_exp(1'b1, 1'b1, 8'd0, 10'd0), "R10 after reset");

        // R1: non-acknowledge function code with strobe low
        fc_i = 3'b101; lvl_i = 3'd3; as_n_i = 1'b0; auto_cfg_i = 8'hFF; dev_valid_i = 8'hFF;
        repeat (3) begin
            @(negedge clk);
            check_out(pack_exp(1'b1, 1'b1, 8'd0, 10'd0), "R1 fc not 111");
        end
        // R1: acknowledge code with strobe high
        fc_i = 3'b111; as_n_i = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check_out(pack_exp(1'b1, 1'b1, 8'd0, 10'd0), "R1 strobe high");
        end
        fc_i = 3'b000;

        for (int l = 1; l < 8; l++) run_ack(l, 1'b1, 0, 8'h00, "R2 autovector");
        run_ack(2, 1'b0, 0, 8'h40, "R3 vector immediate");
        run_ack(5, 1'b0, 3, 8'hC7, "R3 vector delayed");
        run_ack(7, 1'b0, TO + 1, 8'h55, "R4 timeout");
        run_ack(4, 1'b0, TO + 3, 8'h99, "R4 timeout late device");
        run_ack(3, 1'b0, TO, 8'hA2, "R5 device at timeout edge");
        run_ack(0, 1'b0, 0, 8'h11, "R6 level zero");
        run_ack(0, 1'b1, 0, 8'h11, "R6 level zero auto cfg");

        for (int i = 0; i < 150; i++) begin
            int lv;
            bit au;
            int dl;
            lv = int'($urandom_range(7, 0));
            au = 1'($urandom);
            dl = int'($urandom_range(TO + 2, 0));
            run_ack(lv, au, dl, 8'($urandom), au ? "R2 random" : "R3 random");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule